// File: doc/BRIEF.md
# Flash Sector Address and Buffer Decoder

This block sits between a register bus and the data mover of a 2 KB-page NAND-style flash controller. Software writes eight 16-bit start-address registers and one start-buffer register. From their contents the block keeps a set of outputs up to date: the linear source sector, the copy-back destination sector, the first sector of a block erase, the number of sectors to move, and which buffer slot takes part. A page holds four 512-byte sectors and a block holds 64 pages, so a block spans 256 sectors.

All outputs are combinational functions of the stored registers. They change in the cycle after the register write that affects them. The register interface is plain control: a write strobe with an index and data, and an index-driven read port that returns data in the same cycle. There is no valid/ready handshake because no data stream passes through the block. The data mover samples the decoded outputs whenever it starts a transfer. An optional high block mask (parameter `DENSITY_MASK`) is ORed into the block number when bit 15 of a block register is set. This is how a device with more blocks selects its upper half.

Top module: `flash_sector_decoder`

## Requirements
- R1: After reset, all eight address registers read 0, the sector count is 1, the buffer address is 0, and the start-buffer register reads 0x0000.
- R2: A write with `wr_en` high to index 0..7 stores the full 16-bit value. The same index reads that value back from the next cycle on.
- R3: `src_sector` equals (page mod 4) + 4 × ((page bits 7:2) + 64 × block field). The block field is taken from register 0 and the page from register 7.
- R4: The block field is bits 11:0 of the block register. When bit 15 of that register is set, `DENSITY_MASK` is ORed into the field. Bits 14:12 never affect it.
- R5: `dst_sector` uses the same formula as R3, with the block field from register 2 and the page from register 3.
- R6: A write to index 8 (start-buffer) stores data bits 11:8 as the buffer address and data bits 1:0 as the count code. `sec_count` is the code, except that code 0 gives 4.
- R7: `buf_is_data` is buffer-address bit 3 (1 means a data buffer, 0 means the boot buffer). `buf_bank` is bit 2. `buf_offset` is bits 1:0.
- R8: Index 8 reads back as (buffer address << 8) | ((sec_count − 1) & 2).
- R9: `erase_sector` equals the register-0 block field × 256.
- R10: Writes to indices 9..15 change nothing, and reads of those indices return 0.
- R11: With `wr_en` low, no stored value or decoded output changes, whatever the index and data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Register index for the write |
| wr_data | input | 16 | Write data |
| rd_idx | input | 4 | Register index for readback |
| rd_data | output | 16 | Readback data, combinational |
| src_sector | output | 20 | Source linear sector |
| dst_sector | output | 20 | Copy-back destination sector |
| erase_sector | output | 20 | First sector of block erase |
| sec_count | output | 3 | Sectors to transfer, 1..4 |
| buf_is_data | output | 1 | Data buffer (1) or boot buffer (0) |
| buf_bank | output | 1 | Data buffer number |
| buf_offset | output | 2 | Sector offset inside the buffer |

## Verification
The bench sets block bit 15 both with and without high bits 14:12 set. A decoder that leaks those bits, or that ignores the density bit, would return a different block field. Count code 0 is checked as four sectors, and the start-buffer readback is checked for all four counts. A design that stored the literal code, or that reported count minus one unmasked, would show up in the bit-1 pattern. Writes to unmapped indices, and idle cycles with live-looking data on the inputs, are followed by full readback and output checks, which catch any stray write decode.

// File: rtl/flash_dec_pkg.sv
package flash_dec_pkg;
  localparam int REG_W      = 16;
  localparam int IDX_W      = 4;
  localparam int N_ADDR     = 8;
  localparam int BUF_IDX    = 8;
  localparam int SRC_BLK    = 0;
  localparam int SRC_PAGE   = 7;
  localparam int DST_BLK    = 2;
  localparam int DST_PAGE   = 3;
  localparam int DENS_BIT   = 15;

  typedef struct packed {
    logic       is_data;
    logic       bank;
    logic [1:0] offset;
  } buf_sel_t;
endpackage

// File: rtl/addr_regfile.sv
module addr_regfile
  import flash_dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [REG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [REG_W-1:0] rd_data,
  output logic [REG_W-1:0] src_blk_q,
  output logic [REG_W-1:0] src_page_q,
  output logic [REG_W-1:0] dst_blk_q,
  output logic [REG_W-1:0] dst_page_q,
  output logic [3:0]       bufaddr_q,
  output logic [1:0]       cnt_code_q
);
  logic [REG_W-1:0] areg [N_ADDR];

  generate
    for (genvar g = 0; g < N_ADDR; g++) begin : g_areg
      always_ff @(posedge clk) begin
        if (!rst_n)
          areg[g] <= '0;
        else if (wr_en && wr_idx == IDX_W'(g))
          areg[g] <= wr_data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bufaddr_q  <= 4'd0;
      cnt_code_q <= 2'd1;
    end else if (wr_en && wr_idx == IDX_W'(BUF_IDX)) begin
      bufaddr_q  <= wr_data[11:8];
      cnt_code_q <= wr_data[1:0];
    end
  end

  logic [2:0] cnt_m1;
  always_comb begin
    cnt_m1 = (cnt_code_q == 2'd0) ? 3'd3 : {1'b0, cnt_code_q} - 3'd1;
  end

  always_comb begin
    rd_data = '0;
    if (rd_idx < IDX_W'(N_ADDR))
      rd_data = areg[rd_idx[2:0]];
    else if (rd_idx == IDX_W'(BUF_IDX))
      rd_data = {4'd0, bufaddr_q, 6'd0, cnt_m1[1] , 1'b0};
  end

  assign src_blk_q  = areg[SRC_BLK];
  assign src_page_q = areg[SRC_PAGE];
  assign dst_blk_q  = areg[DST_BLK];
  assign dst_page_q = areg[DST_PAGE];

  // R2: a write lands in the addressed register
  p_addr_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx < IDX_W'(N_ADDR)) |=> areg[$past(wr_idx[2:0])] == $past(wr_data));

  // R6: count code follows the start-buffer write
  p_count_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_W'(BUF_IDX)) |=> cnt_code_q == $past(wr_data[1:0]));

  // R10: unmapped indices leave all state alone
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx > IDX_W'(BUF_IDX)) |=>
      $stable(bufaddr_q) && $stable(cnt_code_q) && $stable(src_blk_q) && $stable(dst_page_q));

  // R11: no strobe, no change
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bufaddr_q) && $stable(cnt_code_q) && $stable(src_page_q) && $stable(dst_blk_q));
endmodule

// File: rtl/blk_field_ext.sv
module blk_field_ext
  import flash_dec_pkg::*;
#(
  parameter int               BLK_W        = 12,
  parameter logic [BLK_W-1:0] DENSITY_MASK = '0
) (
  input  logic [REG_W-1:0] blk_reg,
  output logic [BLK_W-1:0] blk_field
);
  logic unused_hi;
  assign unused_hi = &{1'b0, blk_reg[DENS_BIT-1:BLK_W]};

  always_comb begin
    blk_field = blk_reg[BLK_W-1:0];
    if (blk_reg[DENS_BIT])
      blk_field = blk_field | DENSITY_MASK;
  end
endmodule

// File: rtl/sector_calc.sv
module sector_calc
  import flash_dec_pkg::*;
#(
  parameter int               BLK_W        = 12,
  parameter int               PG_W         = 6,
  parameter int               SUB_W        = 2,
  parameter logic [BLK_W-1:0] DENSITY_MASK = '0,
  localparam int              SEC_W        = BLK_W + PG_W + SUB_W
) (
  input  logic [REG_W-1:0] blk_reg,
  input  logic [REG_W-1:0] page_reg,
  output logic [SEC_W-1:0] sector
);
  localparam int LOW_W = PG_W + SUB_W;

  logic [BLK_W-1:0] fld;
  logic             unused_pg;

  blk_field_ext #(.BLK_W(BLK_W), .DENSITY_MASK(DENSITY_MASK)) u_fld (
    .blk_reg  (blk_reg),
    .blk_field(fld)
  );

  assign unused_pg = &{1'b0, page_reg[REG_W-1:LOW_W]};
  assign sector    = {fld, page_reg[LOW_W-1:0]};
endmodule

// File: rtl/buf_decode.sv
module buf_decode
  import flash_dec_pkg::*;
(
  input  logic [3:0] bufaddr,
  input  logic [1:0] cnt_code,
  output buf_sel_t   sel,
  output logic [2:0] count
);
  always_comb begin
    sel.is_data = bufaddr[3];
    sel.bank    = bufaddr[2];
    sel.offset  = bufaddr[1:0];
    count       = (cnt_code == 2'd0) ? 3'd4 : {1'b0, cnt_code};
  end

  always_comb begin
    if (count != 3'd0)
      p_count_nonzero_r6: assert (count <= 3'd4);
  end
endmodule

// File: rtl/flash_sector_decoder.sv
module flash_sector_decoder
  import flash_dec_pkg::*;
#(
  parameter int                BLK_W        = 12,
  parameter logic [BLK_W-1:0]  DENSITY_MASK = 12'h400,
  localparam int               PG_W         = 6,
  localparam int               SUB_W        = 2,
  localparam int               SEC_W        = BLK_W + PG_W + SUB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_idx,
  input  logic [15:0]      wr_data,
  input  logic [3:0]       rd_idx,
  output logic [15:0]      rd_data,
  output logic [SEC_W-1:0] src_sector,
  output logic [SEC_W-1:0] dst_sector,
  output logic [SEC_W-1:0] erase_sector,
  output logic [2:0]       sec_count,
  output logic             buf_is_data,
  output logic             buf_bank,
  output logic [1:0]       buf_offset
);
  logic [REG_W-1:0] blk_r [2];
  logic [REG_W-1:0] pg_r  [2];
  logic [SEC_W-1:0] sec_r [2];
  logic [3:0]       bufaddr;
  logic [1:0]       cnt_code;
  logic [BLK_W-1:0] erase_fld;
  buf_sel_t         sel;

  addr_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .src_blk_q (blk_r[0]),
    .src_page_q(pg_r[0]),
    .dst_blk_q (blk_r[1]),
    .dst_page_q(pg_r[1]),
    .bufaddr_q (bufaddr),
    .cnt_code_q(cnt_code)
  );

  generate
    for (genvar p = 0; p < 2; p++) begin : g_sec
      sector_calc #(
        .BLK_W(BLK_W), .PG_W(PG_W), .SUB_W(SUB_W), .DENSITY_MASK(DENSITY_MASK)
      ) u_calc (
        .blk_reg (blk_r[p]),
        .page_reg(pg_r[p]),
        .sector  (sec_r[p])
      );
    end
  endgenerate

  blk_field_ext #(.BLK_W(BLK_W), .DENSITY_MASK(DENSITY_MASK)) u_erase_fld (
    .blk_reg  (blk_r[0]),
    .blk_field(erase_fld)
  );

  buf_decode u_buf (
    .bufaddr (bufaddr),
    .cnt_code(cnt_code),
    .sel     (sel),
    .count   (sec_count)
  );

  assign src_sector   = sec_r[0];
  assign dst_sector   = sec_r[1];
  assign erase_sector = {erase_fld, {(PG_W + SUB_W){1'b0}}};
  assign buf_is_data  = sel.is_data;
  assign buf_bank     = sel.bank;
  assign buf_offset   = sel.offset;

  // R11: decoded outputs hold while no write is strobed
  p_outputs_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(src_sector) && $stable(dst_sector) && $stable(erase_sector)
               && $stable(sec_count) && $stable(buf_offset));

  // R9: erase start tracks the source block with the page ignored
  p_erase_page_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd7) |=> $stable(erase_sector));
endmodule

// File: tb/sim_flash_sector_decoder.sv
`timescale 1ns/1ps
module sim_flash_sector_decoder;
  localparam logic [11:0] MASK = 12'h400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_idx = '0;
  logic [15:0] rd_data;
  logic [19:0] src_sector, dst_sector, erase_sector;
  logic [2:0]  sec_count;
  logic        buf_is_data, buf_bank;
  logic [1:0]  buf_offset;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_sector_decoder #(.DENSITY_MASK(MASK)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .src_sector(src_sector), .dst_sector(dst_sector),
    .erase_sector(erase_sector), .sec_count(sec_count), .buf_is_data(buf_is_data),
    .buf_bank(buf_bank), .buf_offset(buf_offset)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  function automatic logic [11:0] fld(input logic [15:0] b);
    fld = b[11:0] | (b[15] ? MASK : 12'h0);
  endfunction

  function automatic logic [19:0] sec_of(input logic [15:0] b, input logic [15:0] p);
    int s;
    s = (p & 3) + ((((p >> 2) & 'h3F) + (int'(fld(b)) * 64)) * 4);
    sec_of = 20'(s);
  endfunction

  task automatic wr(input logic [3:0] i, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] i, output logic [15:0] d);
    rd_idx = i;
    #0.5;
    d = rd_data;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int i = 0; i < 9; i++) begin
      rd(4'(i), v);
      check("R1 reset readback", {16'h0, v}, 32'h0);
    end
    check("R1 reset count", {29'h0, sec_count}, 32'd1);
    check("R1 reset src", {12'h0, src_sector}, 32'h0);
    check("R1 reset buf", {28'h0, buf_is_data, buf_bank, buf_offset}, 32'h0);
  endtask

  task automatic t_src;
    logic [15:0] v;
    wr(4'd0, 16'h0123);
    wr(4'd7, 16'h00B6);
    rd(4'd7, v);
    check("R2 readback reg7", {16'h0, v}, 32'h00B6);
    check("R3 src sector", {12'h0, src_sector}, {12'h0, sec_of(16'h0123, 16'h00B6)});
    check("R9 erase sector", {12'h0, erase_sector}, {12'h0, 20'(int'(fld(16'h0123)) * 256)});
    wr(4'd7, 16'hFF03);
    check("R3 page high bits", {12'h0, src_sector}, {12'h0, sec_of(16'h0123, 16'h0003)});
    check("R9 erase page free", {12'h0, erase_sector}, {12'h0, 20'h12300});
  endtask

  task automatic t_density;
    wr(4'd0, 16'h8005);
    check("R4 density bit", {12'h0, src_sector}, {12'h0, sec_of(16'h8005, 16'hFF03)});
    check("R4 density erase", {12'h0, erase_sector}, 32'h40500);
    wr(4'd0, 16'h7123);
    check("R4 bits 14:12 ignored", {12'h0, erase_sector}, 32'h12300);
    wr(4'd0, 16'hF123);
    check("R4 both", {12'h0, erase_sector}, 32'h52300);
  endtask

  task automatic t_dst;
    wr(4'd2, 16'h0FFF);
    wr(4'd3, 16'h00FF);
    check("R5 dst max", {12'h0, dst_sector}, {12'h0, sec_of(16'h0FFF, 16'h00FF)});
    wr(4'd2, 16'h0010);
    wr(4'd3, 16'h0041);
    check("R5 dst", {12'h0, dst_sector}, {12'h0, sec_of(16'h0010, 16'h0041)});
  endtask

  task automatic t_buf;
    logic [15:0] v;
    wr(4'd8, 16'h0C03);
    rd(4'd8, v);
    check("R6 count 3", {29'h0, sec_count}, 32'd3);
    check("R7 sel C", {28'h0, buf_is_data, buf_bank, buf_offset}, 32'hC);
    check("R8 readback c3", {16'h0, v}, 32'h0C02);
    wr(4'd8, 16'h0A00);
    rd(4'd8, v);
    check("R6 code 0 is 4", {29'h0, sec_count}, 32'd4);
    check("R7 sel A", {28'h0, buf_is_data, buf_bank, buf_offset}, 32'hA);
    check("R8 readback c4", {16'h0, v}, 32'h0A02);
    wr(4'd8, 16'h0302);
    rd(4'd8, v);
    check("R6 count 2", {29'h0, sec_count}, 32'd2);
    check("R7 boot buffer", {28'h0, buf_is_data, buf_bank, buf_offset}, 32'h3);
    check("R8 readback c2", {16'h0, v}, 32'h0300);
    wr(4'd8, 16'hF5F1);
    rd(4'd8, v);
    check("R6 count 1", {29'h0, sec_count}, 32'd1);
    check("R8 readback c1", {16'h0, v}, 32'h0500);
  endtask

  task automatic t_unmapped;
    logic [15:0] v;
    for (int i = 9; i < 16; i++) wr(4'(i), 16'hFFFF);
    for (int i = 9; i < 16; i++) begin
      rd(4'(i), v);
      check("R10 unmapped read", {16'h0, v}, 32'h0);
    end
    rd(4'd8, v);
    check("R10 buf unchanged", {16'h0, v}, 32'h0500);
    rd(4'd0, v);
    check("R10 reg0 unchanged", {16'h0, v}, 32'hF123);
    check("R10 dst unchanged", {12'h0, dst_sector}, {12'h0, sec_of(16'h0010, 16'h0041)});
  endtask

  task automatic t_idle;
    logic [15:0] v;
    @(negedge clk);
    wr_en = 1'b0; wr_idx = 4'd0; wr_data = 16'hABCD;
    @(negedge clk);
    wr_idx = 4'd8;
    @(negedge clk);
    rd(4'd0, v);
    check("R11 reg0 idle", {16'h0, v}, 32'hF123);
    rd(4'd8, v);
    check("R11 buf idle", {16'h0, v}, 32'h0500);
    check("R11 count idle", {29'h0, sec_count}, 32'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_src();
    t_density();
    t_dst();
    t_buf();
    t_unmapped();
    t_idle();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule